// File: doc/BRIEF.md
# Configurable Output Macrocell for a Sum-of-Products Logic Array

This block is one output cell of a programmable sum-of-products device. It receives the product-term results for its slot from the logic array: a combinatorial data term, a pair of next-state terms for its flip-flop, set and clear terms, a per-cell clock term and an output-enable term. Static configuration inputs choose the cell's mode, whether the driven value is inverted, whether the flip-flop behaves as J-K or D, which clock source it follows and which enable source gates the pin driver. The cell returns the pin drive value, the pin enable and two feedback signals to the array: one carrying the pin level and one carrying the flip-flop state.

The cell's main feature is that its flip-flop is never lost. When the pin is driven combinatorially, the flip-flop keeps running as a buried register. It takes its own next-state terms and has its own feedback line, so one cell can carry a combinatorial output and an unrelated state bit at the same time. A synchronous preload input forces a chosen value into the flip-flop for test. It takes priority over every other way the flip-flop can change.

The whole block runs on one system clock. The two register clock sources, the shared clock pin and the per-cell clock term, are sampled levels. A rising edge on the selected source, seen between two system clock edges, lets the flip-flop take its next-state value. The set and clear terms act at every system clock edge, whichever clock source is selected.

Top module: `omc_cell`

## Requirements
- R1: In J-K mode (`cfg_dtype`=0), in the registered-output mode (`cfg_mode`=0) or the buried-register mode (`cfg_mode`=2), a clock tick acts on (J,K) as follows: (0,0) holds, (0,1) clears, (1,0) sets and (1,1) toggles the flip-flop.
- R2: In D mode (`cfg_dtype`=1), in `cfg_mode` 0 or 2, a clock tick loads `j_term` and ignores `k_term`.
- R3: In the registered-input mode (`cfg_mode`=1), a clock tick loads `pin_in` into the flip-flop, and `pin_oe` is 0.
- R4: With no preload, an active `clr_term` clears the flip-flop at the next system clock edge, even when `set_term` is also active. `set_term` alone sets it.
- R5: `pre_en`=1 loads `pre_val` into the flip-flop at the next system clock edge, overriding the clear, set and next-state terms.
- R6: With no preload, no set, no clear and no tick, the flip-flop holds its value.
- R7: A tick is a 0-to-1 change of the selected source between successive system clock edges. `cfg_clk_sel`=0 selects `clk_pin` and `cfg_clk_sel`=1 selects `clk_term`. Edges on the source that is not selected do not advance the flip-flop.
- R8: `pin_out` is flip-flop Q XOR `cfg_invert` in `cfg_mode` 0, is `comb_term` XOR `cfg_invert` in `cfg_mode` 2 and 3, and is 0 in all other modes.
- R9: In `cfg_mode` 0, 2 and 3, `pin_oe` follows `oe_pin` when `cfg_oe_sel`=0 and `oe_term` when `cfg_oe_sel`=1. In `cfg_mode` 1 and in 4 through 7 (dedicated input), `pin_oe` is 0.
- R10: In `cfg_mode` 2, the flip-flop keeps advancing on ticks from `j_term`/`k_term`, independently of the combinatorial value on `pin_out`.
- R11: In `cfg_mode` 3 and in 4 through 7, ticks do not change the flip-flop. Preload, set and clear still apply.
- R12: `fb_reg` always equals flip-flop Q. `fb_pin` always equals `pin_out` when `pin_oe`=1 and `pin_in` otherwise.
- R13: A system clock edge with `rst_n`=0 clears the flip-flop and the clock-edge history, taking priority over preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Cell mode: 0 registered out, 1 registered in, 2 comb + buried reg, 3 comb I/O, 4-7 input |
| cfg_invert | input | 1 | Invert the driven value |
| cfg_dtype | input | 1 | 0 J-K flip-flop, 1 D flip-flop |
| cfg_clk_sel | input | 1 | 0 shared clock pin, 1 per-cell clock term |
| cfg_oe_sel | input | 1 | 0 enable pin, 1 enable term |
| comb_term | input | 1 | Combinatorial data term |
| j_term | input | 1 | J (or D) next-state term |
| k_term | input | 1 | K next-state term |
| set_term | input | 1 | Preset term |
| clr_term | input | 1 | Clear term |
| clk_term | input | 1 | Per-cell clock term level |
| oe_term | input | 1 | Output-enable term |
| clk_pin | input | 1 | Shared clock pin level |
| oe_pin | input | 1 | Shared enable pin |
| pin_in | input | 1 | Level seen on the pad |
| pre_en | input | 1 | Preload strobe |
| pre_val | input | 1 | Preload value |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable |
| fb_pin | output | 1 | Pin-level feedback to array |
| fb_reg | output | 1 | Flip-flop feedback to array |

## Verification
The cell has no size parameters, so the bench builds it with its defaults and treats the configuration inputs as the swept dimension. All 128 combinations of mode, inversion, flip-flop type, clock source and enable source are stepped through, including the three unused mode codes. Each combination gets 64 cycles of pseudo-random array terms and clock levels, with resets inserted between groups. This covers every J-K pair, set against clear, preload against everything, and edges on the source that is not selected, in every mode.

// File: rtl/omc_pkg.sv
// Package: shared mode codes and mode decoding helpers for the output cell.
// Assumes cfg_mode is static while the cell operates; codes 4..7 all mean input.
package omc_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_REG_OUT  = 3'd0,
        MD_REG_IN   = 3'd1,
        MD_COMB_BUR = 3'd2,
        MD_COMB_IO  = 3'd3,
        MD_INPUT    = 3'd4
    } omc_mode_e;

    // True when the mode lets the cell drive its pin.
    function automatic logic mode_drives(input logic [MODE_W-1:0] m);
        return (m == MD_REG_OUT) || (m == MD_COMB_BUR) || (m == MD_COMB_IO);
    endfunction

    // True when ticks may advance the flip-flop.
    function automatic logic mode_clocks(input logic [MODE_W-1:0] m);
        return (m == MD_REG_OUT) || (m == MD_REG_IN) || (m == MD_COMB_BUR);
    endfunction

endpackage

// File: rtl/omc_clk_pick.sv
// Module: picks the register clock source and turns its rising edge into a
// one-cycle tick in the system clock domain.
// Assumes both sources are levels already synchronous to clk.
module omc_clk_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_term,
    input  logic src_pin,
    input  logic src_term,
    output logic tick
);

    logic src_now;
    logic src_last;

    // Select the source level named by the configuration.
    always_comb begin
        src_now = sel_term ? src_term : src_pin;
    end

    // Remember the selected level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_last <= 1'b0;
        end else begin
            src_last <= src_now;
        end
    end

    // A tick is a low-to-high change since the previous edge.
    always_comb begin
        tick = src_now & ~src_last;
    end

endmodule

// File: rtl/omc_store.sv
// Module: the cell's storage element, J-K or D, with preload, clear and set.
// Priority at each edge: reset, preload, clear, set, ticked next state.
// Assumes adv already includes the mode gating.
module omc_store (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic as_d,
    input  logic j_in,
    input  logic k_in,
    input  logic pre_en,
    input  logic pre_val,
    input  logic clr,
    input  logic set,
    output logic q
);

    logic nxt;

    // Next-state value from the J-K table or the D input.
    always_comb begin
        if (as_d) begin
            nxt = j_in;
        end else begin
            unique case ({j_in, k_in})
                2'b00:   nxt = q;
                2'b01:   nxt = 1'b0;
                2'b10:   nxt = 1'b1;
                default: nxt = ~q;
            endcase
        end
    end

    // State update in fixed priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (pre_en) begin
            q <= pre_val;
        end else if (clr) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (adv) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/omc_drive.sv
// Module: pin-side logic of the cell: drive value, enable and pin feedback.
// Purely combinatorial; assumes q is the stored flip-flop state.
module omc_drive
    import omc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              invert,
    input  logic              oe_sel,
    input  logic              oe_pin,
    input  logic              oe_term,
    input  logic              comb,
    input  logic              q,
    input  logic              pad_in,
    output logic              drv,
    output logic              drv_en,
    output logic              pad_fb
);

    logic src;
    logic drives;

    // Pick the value routed toward the pin.
    always_comb begin
        drives = mode_drives(mode);
        src    = (mode == MD_REG_OUT) ? q : comb;
        drv    = drives ? (src ^ invert) : 1'b0;
    end

    // Pick the enable source; input modes never drive.
    always_comb begin
        drv_en = drives & (oe_sel ? oe_term : oe_pin);
    end

    // The pad level: our own drive when enabled, else the outside level.
    always_comb begin
        pad_fb = drv_en ? drv : pad_in;
    end

endmodule

// File: rtl/omc_cell.sv
// Module: top of one configurable output macrocell. Joins clock selection,
// storage and pin logic. In the buried-register mode the flip-flop keeps
// running from its own terms while the pin carries the combinatorial term.
// Assumes configuration inputs are static during operation.
module omc_cell
    import omc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_invert,
    input  logic              cfg_dtype,
    input  logic              cfg_clk_sel,
    input  logic              cfg_oe_sel,
    input  logic              comb_term,
    input  logic              j_term,
    input  logic              k_term,
    input  logic              set_term,
    input  logic              clr_term,
    input  logic              clk_term,
    input  logic              oe_term,
    input  logic              clk_pin,
    input  logic              oe_pin,
    input  logic              pin_in,
    input  logic              pre_en,
    input  logic              pre_val,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_pin,
    output logic              fb_reg
);

    logic tick;
    logic adv;
    logic as_d;
    logic j_sel;
    logic q;

    omc_clk_pick u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_term (cfg_clk_sel),
        .src_pin  (clk_pin),
        .src_term (clk_term),
        .tick     (tick)
    );

    // Route the flip-flop inputs: pin capture in registered-input mode.
    always_comb begin
        adv   = tick & mode_clocks(cfg_mode);
        as_d  = cfg_dtype | (cfg_mode == MD_REG_IN);
        j_sel = (cfg_mode == MD_REG_IN) ? pin_in : j_term;
    end

    omc_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .as_d    (as_d),
        .j_in    (j_sel),
        .k_in    (k_term),
        .pre_en  (pre_en),
        .pre_val (pre_val),
        .clr     (clr_term),
        .set     (set_term),
        .q       (q)
    );

    omc_drive u_drive (
        .mode    (cfg_mode),
        .invert  (cfg_invert),
        .oe_sel  (cfg_oe_sel),
        .oe_pin  (oe_pin),
        .oe_term (oe_term),
        .comb    (comb_term),
        .q       (q),
        .pad_in  (pin_in),
        .drv     (pin_out),
        .drv_en  (pin_oe),
        .pad_fb  (fb_pin)
    );

    // Register feedback is the stored state in every mode.
    always_comb begin
        fb_reg = q;
    end

endmodule

// Checker: port-level properties of the output cell.
module omc_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_mode,
    input logic       cfg_invert,
    input logic       comb_term,
    input logic       set_term,
    input logic       clr_term,
    input logic       pre_en,
    input logic       pre_val,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       fb_reg
);

    logic rst_seen;

    // Track whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // R13: after a reset edge the flip-flop reads 0.
    always @(posedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r13_reset_clear: assert (fb_reg == 1'b0);
        end
    end

    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_en && clr_term) |=> !fb_reg);

    a_r4_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_en && !clr_term && set_term) |=> fb_reg);

    a_r5_preload: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> (fb_reg == $past(pre_val)));

    a_r3_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd1) |-> !pin_oe);

    a_r9_input_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode >= 3'd4) |-> (!pin_oe && !pin_out));

    a_r8_comb_path: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 3'd2 || cfg_mode == 3'd3) |-> (pin_out == (comb_term ^ cfg_invert)));

    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode >= 3'd3) && !pre_en && !clr_term && !set_term) |=> $stable(fb_reg));

endmodule

bind omc_cell omc_cell_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_invert (cfg_invert),
    .comb_term  (comb_term),
    .set_term   (set_term),
    .clr_term   (clr_term),
    .pre_en     (pre_en),
    .pre_val    (pre_val),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .fb_reg     (fb_reg)
);

// File: tb/sim_omc_cell.sv
// Bench: sweeps every configuration with pseudo-random array terms and checks
// outputs against a model written from the requirements.
module sim_omc_cell;

    localparam int CLK_PERIOD = 10;
    localparam int CYC_PER_CFG = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_mode;
    logic       cfg_invert, cfg_dtype, cfg_clk_sel, cfg_oe_sel;
    logic       comb_term, j_term, k_term, set_term, clr_term, clk_term, oe_term;
    logic       clk_pin, oe_pin, pin_in, pre_en, pre_val;
    logic       pin_out, pin_oe, fb_pin, fb_reg;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    logic [31:0] lf = 32'h1D3A_95C7;
    logic m_q;
    logic m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    omc_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
        .cfg_dtype(cfg_dtype), .cfg_clk_sel(cfg_clk_sel), .cfg_oe_sel(cfg_oe_sel),
        .comb_term(comb_term), .j_term(j_term), .k_term(k_term), .set_term(set_term),
        .clr_term(clr_term), .clk_term(clk_term), .oe_term(oe_term), .clk_pin(clk_pin),
        .oe_pin(oe_pin), .pin_in(pin_in), .pre_en(pre_en), .pre_val(pre_val),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_pin(fb_pin), .fb_reg(fb_reg)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b mode=%0d t=%0t", tag, act, exp, cfg_mode, $time);
        end
    endtask

    task automatic rnd();
        for (int i = 0; i < 3; i++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        comb_term = lf[0];  j_term  = lf[1];  k_term  = lf[2];
        clk_term  = lf[3];  clk_pin = lf[4];  oe_term = lf[5];
        oe_pin    = lf[6];  pin_in  = lf[7];  pre_val = lf[8];
        pre_en    = lf[9] & lf[10] & lf[11];
        clr_term  = lf[12] & lf[13] & lf[14];
        set_term  = lf[15] & lf[16];
    endtask

    // One cycle: check pin-side outputs, then the flip-flop after the edge.
    task automatic one_cycle();
        logic drives, e_oe, e_out, e_fb, sel, oth, tick, clocks, e_q;
        string tag;
        #1;
        drives = (cfg_mode == 0) || (cfg_mode == 2) || (cfg_mode == 3);
        e_oe   = drives & (cfg_oe_sel ? oe_term : oe_pin);
        e_out  = !drives ? 1'b0 : ((cfg_mode == 0) ? (m_q ^ cfg_invert) : (comb_term ^ cfg_invert));
        e_fb   = e_oe ? e_out : pin_in;
        chk("R8 pin_out", pin_out, e_out);
        chk((cfg_mode == 1) ? "R3 pin_oe" : "R9 pin_oe", pin_oe, e_oe);
        chk("R12 fb_pin", fb_pin, e_fb);
        sel    = cfg_clk_sel ? clk_term : clk_pin;
        oth    = cfg_clk_sel ? clk_pin : clk_term;
        tick   = sel & ~m_prev;
        clocks = (cfg_mode <= 2);
        e_q = m_q;
        if (pre_en) begin e_q = pre_val; tag = "R5 preload"; end
        else if (clr_term) begin e_q = 1'b0; tag = "R4 clear"; end
        else if (set_term) begin e_q = 1'b1; tag = "R4 set"; end
        else if (!tick) tag = oth ? "R7 unselected edge" : "R6 hold";
        else if (!clocks) tag = "R11 frozen";
        else if (cfg_mode == 1) begin e_q = pin_in; tag = "R3 capture"; end
        else if (cfg_dtype) begin e_q = j_term; tag = "R2 d load"; end
        else begin
            case ({j_term, k_term})
                2'b00: e_q = m_q;
                2'b01: e_q = 1'b0;
                2'b10: e_q = 1'b1;
                default: e_q = ~m_q;
            endcase
            tag = (cfg_mode == 2) ? "R10 buried jk" : "R1 jk";
        end
        @(posedge clk);
        m_prev = sel;
        m_q    = e_q;
        #1;
        chk(tag, fb_reg, e_q);
        chk("R12 fb_reg", fb_reg, m_q);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rnd();
        pre_en = 1'b1;
        pre_val = 1'b1;
        @(posedge clk);
        #1;
        m_q = 1'b0;
        m_prev = 1'b0;
        chk("R13 reset", fb_reg, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        {cfg_mode, cfg_invert, cfg_dtype, cfg_clk_sel, cfg_oe_sel} = '0;
        rnd();
        m_q = 1'b0;
        m_prev = 1'b0;
        @(posedge clk);
        #1;
        do_reset();
        for (int c = 0; c < 128; c++) begin
            cfg_mode    = c[2:0];
            cfg_invert  = c[3];
            cfg_dtype   = c[4];
            cfg_clk_sel = c[5];
            cfg_oe_sel  = c[6];
            if (c[3:0] == 4'd9) do_reset();
            for (int n = 0; n < CYC_PER_CFG; n++) begin
                rnd();
                one_cycle();
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule